// File: doc/BRIEF.md
# Synthesizer Self-Calibration Sequencer

This block decides when the frequency synthesizer of a radio is recalibrated and judges whether the calibration produced lock. A calibration can be started in two ways. A 2-bit configuration field selects an automatic trigger on the synthesizer's switch-on event, on its switch-off event, or on neither. Separately, a manual strobe starts a calibration, but only while the radio rests in its idle state. Any start request that arrives while a calibration is already running is dropped.

The calibration engine itself is abstracted. It takes a fixed, parameterized number of clock cycles. At the end of that time it hands back the 6-bit code that is presented on `trial_code`. The code is stored as the calibration result. The all-ones code signals a failed lock, and any other value signals lock. A failed attempt is repeated at once, with no gap, until lock is reached or a parameterized attempt limit is used up. When the limit runs out, an error flag is raised.

The stored result is never cleared by a sleep period, so it remains valid after wake-up. A one-cycle lock pulse is suitable for driving an interrupt line.

Top module: `synth_cal_seq`

## Requirements
- R1: After reset, `busy`, `cal_req`, `locked`, `lock_irq` and `cal_error` are 0, and `cal_result` holds 6'h3F.
- R2: `auto_mode` 1 starts a calibration on a `synth_on` pulse, and `auto_mode` 2 starts one on a `synth_off` pulse. Values 0 and 3 start nothing on either event.
- R3: `radio_state` encodes 0 = idle, 1 = sleep, and 2 or 3 = active. `cal_strobe` starts a calibration only when `radio_state` is 0.
- R4: Each attempt keeps `busy` high for exactly CAL_CYCLES cycles, and `cal_req` pulses in its first cycle only. `trial_code` is sampled in the attempt's last cycle and appears on `cal_result` in the cycle after it.
- R5: While not busy, `locked` is 1 exactly when `cal_result` differs from 6'h3F. A fresh start clears `locked`.
- R6: `lock_irq` is a one-cycle pulse in the first cycle in which `locked` is 1.
- R7: An attempt that ends with code 6'h3F starts the next attempt in the following cycle. `busy` stays high across the boundary, and a new `cal_req` pulse is issued.
- R8: After MAX_ATTEMPTS failed attempts in a row, `busy` drops and `cal_error` rises. The next fresh start clears `cal_error`.
- R9: Start requests (strobe or automatic events) that arrive while `busy` is high are ignored.
- R10: `cal_result` and `locked` are unchanged while the radio is in sleep and after it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 2 | Automatic trigger select (0 none, 1 on, 2 off, 3 none) |
| synth_on | input | 1 | One-cycle pulse: synthesizer switched on |
| synth_off | input | 1 | One-cycle pulse: synthesizer switched off |
| radio_state | input | 2 | Radio state (0 idle, 1 sleep, 2/3 active) |
| cal_strobe | input | 1 | Manual calibration request |
| trial_code | input | 6 | Code returned by the abstracted engine at attempt end |
| cal_req | output | 1 | Pulse marking the first cycle of each attempt |
| busy | output | 1 | High while an attempt runs |
| cal_result | output | 6 | Stored calibration code |
| locked | output | 1 | Lock flag |
| lock_irq | output | 1 | One-cycle lock-reached pulse |
| cal_error | output | 1 | Attempt limit exhausted without lock |

## Verification
The properties assume that `synth_on`, `synth_off` and `cal_strobe` are synchronous to `clk`. They also assume that `trial_code` is settled in an attempt's last cycle and that reset is applied before any event.

The stimulus drives every input on the falling edge. It changes `trial_code` only between attempts, or in the first cycle of a retry. Start requests are held through a whole running attempt so that the ignore rule is tested right up to the attempt's final cycle. The stimulus never lets a request overlap the cycle in which `busy` falls.

// File: rtl/synth_cal_pkg.sv
package synth_cal_pkg;

    localparam int CODE_W = 6;
    localparam logic [CODE_W-1:0] CODE_UNLOCKED = '1;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_SLEEP  = 2'd1,
        RS_ACTIVE = 2'd2,
        RS_ALT    = 2'd3
    } radio_state_e;

    typedef enum logic [1:0] {
        AM_NONE = 2'd0,
        AM_ON   = 2'd1,
        AM_OFF  = 2'd2,
        AM_RSVD = 2'd3
    } auto_mode_e;

endpackage

// File: rtl/synth_cal_trigger.sv
module synth_cal_trigger
    import synth_cal_pkg::*;
(
    input  logic       busy,
    input  logic [1:0] auto_mode,
    input  logic       synth_on,
    input  logic       synth_off,
    input  logic [1:0] radio_state,
    input  logic       cal_strobe,
    output logic       fresh_start
);

    logic auto_hit;
    logic manual_hit;

    always_comb begin
        case (auto_mode_e'(auto_mode))
            AM_ON:   auto_hit = synth_on;
            AM_OFF:  auto_hit = synth_off;
            default: auto_hit = 1'b0;
        endcase
        manual_hit  = cal_strobe && (radio_state_e'(radio_state) == RS_IDLE);
        fresh_start = !busy && (auto_hit || manual_hit);
    end

endmodule

// File: rtl/synth_cal_timer.sv
module synth_cal_timer #(
    parameter int CAL_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic req,
    output logic done
);

    localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CAL_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic             req;
        logic [CNT_W-1:0] cnt;
    } timer_s;

    timer_s st_d, st_q;

    assign done = st_q.busy && (st_q.cnt == '0);
    assign busy = st_q.busy;
    assign req  = st_q.req;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.req  = 1'b1;
            st_d.cnt  = CNT_LOAD;
        end else if (done) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/synth_cal_lock_tracker.sv
module synth_cal_lock_tracker
    import synth_cal_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fresh_start,
    input  logic              done,
    input  logic [CODE_W-1:0] trial_code,
    output logic              retry,
    output logic [CODE_W-1:0] result,
    output logic              locked,
    output logic              lock_irq,
    output logic              error
);

    localparam int ATT_W = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;
    localparam logic [ATT_W-1:0] LAST_ATT = ATT_W'(MAX_ATTEMPTS - 1);

    typedef struct packed {
        logic [CODE_W-1:0] result;
        logic              locked;
        logic              irq;
        logic              error;
        logic [ATT_W-1:0]  attempts;
    } track_s;

    track_s st_d, st_q;
    logic   code_bad;

    always_comb begin
        code_bad = (trial_code == CODE_UNLOCKED);
        retry    = done && code_bad && (st_q.attempts != LAST_ATT);

        st_d = st_q;
        if (fresh_start) begin
            st_d.attempts = '0;
            st_d.locked   = 1'b0;
            st_d.error    = 1'b0;
        end else if (done) begin
            st_d.result = trial_code;
            if (!code_bad) begin
                st_d.locked = 1'b1;
            end else if (retry) begin
                st_d.attempts = st_q.attempts + 1'b1;
            end else begin
                st_d.error = 1'b1;
            end
        end
        st_d.irq = st_d.locked && !st_q.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.result <= CODE_UNLOCKED;
        end else begin
            st_q <= st_d;
        end
    end

    assign result   = st_q.result;
    assign locked   = st_q.locked;
    assign lock_irq = st_q.irq;
    assign error    = st_q.error;

endmodule

// File: rtl/synth_cal_seq.sv
module synth_cal_seq #(
    parameter int CAL_CYCLES   = 64,
    parameter int MAX_ATTEMPTS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] auto_mode,
    input  logic       synth_on,
    input  logic       synth_off,
    input  logic [1:0] radio_state,
    input  logic       cal_strobe,
    input  logic [5:0] trial_code,
    output logic       cal_req,
    output logic       busy,
    output logic [5:0] cal_result,
    output logic       locked,
    output logic       lock_irq,
    output logic       cal_error
);

    logic fresh_start;
    logic retry;
    logic done;
    logic attempt_start;

    synth_cal_trigger u_trigger (
        .busy        (busy),
        .auto_mode   (auto_mode),
        .synth_on    (synth_on),
        .synth_off   (synth_off),
        .radio_state (radio_state),
        .cal_strobe  (cal_strobe),
        .fresh_start (fresh_start)
    );

    assign attempt_start = fresh_start || retry;

    synth_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (attempt_start),
        .busy  (busy),
        .req   (cal_req),
        .done  (done)
    );

    synth_cal_lock_tracker #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .fresh_start (fresh_start),
        .done        (done),
        .trial_code  (trial_code),
        .retry       (retry),
        .result      (cal_result),
        .locked      (locked),
        .lock_irq    (lock_irq),
        .error       (cal_error)
    );

endmodule

// File: rtl/synth_cal_checker.sv
module synth_cal_checker #(
    parameter int CAL_CYCLES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       synth_on,
    input logic       synth_off,
    input logic [1:0] radio_state,
    input logic       cal_strobe,
    input logic       cal_req,
    input logic       busy,
    input logic [5:0] cal_result,
    input logic       locked,
    input logic       lock_irq,
    input logic       cal_error
);

    localparam int PH_W = $clog2(CAL_CYCLES + 2) + 1;
    localparam logic [PH_W-1:0] PH_LIM = PH_W'(CAL_CYCLES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CAL_CYCLES - 1);
    localparam logic MULTI = (CAL_CYCLES > 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (cal_req) begin
            phase_q <= PH_W'(1);
        end else if (busy) begin
            phase_q <= phase_q + 1'b1;
        end else begin
            phase_q <= '0;
        end
    end

    a_r3_strobe_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cal_strobe && radio_state != 2'd0 && !synth_on && !synth_off) |=> !cal_req);

    a_r4_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |-> busy);

    a_r4_attempt_length: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cal_req) |-> (phase_q < PH_LIM));

    a_r9_no_req_midattempt: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cal_req ? MULTI : (phase_q < PH_LAST))) |=> !cal_req);

    a_r5_lock_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (locked == (cal_result != 6'h3F)));

    a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> (locked && !$past(locked)));

    a_r8_error_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        cal_error |-> (!locked && !busy));

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(cal_result));

endmodule

bind synth_cal_seq synth_cal_checker #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .synth_on    (synth_on),
    .synth_off   (synth_off),
    .radio_state (radio_state),
    .cal_strobe  (cal_strobe),
    .cal_req     (cal_req),
    .busy        (busy),
    .cal_result  (cal_result),
    .locked      (locked),
    .lock_irq    (lock_irq),
    .cal_error   (cal_error)
);

// File: tb/sim_synth_cal_seq.sv
`timescale 1ns/1ps
module sim_synth_cal_seq;

    localparam int N   = 5;
    localparam int MAX = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] auto_mode = 2'd0;
    logic       synth_on = 1'b0;
    logic       synth_off = 1'b0;
    logic [1:0] radio_state = 2'd0;
    logic       cal_strobe = 1'b0;
    logic [5:0] trial_code = 6'h01;
    logic       cal_req, busy, locked, lock_irq, cal_error;
    logic [5:0] cal_result;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    synth_cal_seq #(.CAL_CYCLES(N), .MAX_ATTEMPTS(MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .synth_on(synth_on),
        .synth_off(synth_off), .radio_state(radio_state), .cal_strobe(cal_strobe),
        .trial_code(trial_code), .cal_req(cal_req), .busy(busy),
        .cal_result(cal_result), .locked(locked), .lock_irq(lock_irq),
        .cal_error(cal_error)
    );

    always @(posedge clk) begin
        if (cal_req)  req_cnt++;
        if (lock_irq) irq_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe in IDLE, leaves bench at observation point of cycle 1
    task automatic manual_start(input logic [5:0] code);
        trial_code  = code;
        radio_state = 2'd0;
        cal_strobe  = 1'b1;
        cyc(1);
        cal_strobe  = 1'b0;
    endtask

    initial begin
        int r0, i0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 cal_req", cal_req, 0);
        chk("R1 result", cal_result, 6'h3F);
        chk("R1 locked", locked, 0);
        chk("R1 lock_irq", lock_irq, 0);
        chk("R1 error", cal_error, 0);

        // R3 manual strobe over all radio states
        for (int s = 0; s < 4; s++) begin
            trial_code  = 6'h01;
            radio_state = 2'(s);
            cal_strobe  = 1'b1;
            cyc(1);
            cal_strobe  = 1'b0;
            chk("R3 strobe start", cal_req, (s == 0) ? 1 : 0);
            chk("R3 strobe busy", busy, (s == 0) ? 1 : 0);
            cyc(N + 1);
        end
        radio_state = 2'd2;

        // R2 auto mode sweep, both events
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                auto_mode = 2'(m);
                synth_on  = (e == 0);
                synth_off = (e == 1);
                cyc(1);
                synth_on  = 1'b0;
                synth_off = 1'b0;
                chk("R2 auto start", cal_req,
                    ((m == 1 && e == 0) || (m == 2 && e == 1)) ? 1 : 0);
                cyc(N + 1);
            end
        end
        auto_mode = 2'd0;

        // R4 R5 R6 code sweep (all lockable codes)
        for (int c = 0; c < 63; c++) begin
            r0 = req_cnt;
            i0 = irq_cnt;
            manual_start(6'(c));
            for (int k = 1; k <= N; k++) begin
                chk("R4 busy width", busy, 1);
                if (k < N) cyc(1);
            end
            cyc(1);
            chk("R4 busy falls", busy, 0);
            chk("R4 result", cal_result, c);
            chk("R5 locked", locked, 1);
            chk("R6 irq level", lock_irq, 1);
            cyc(1);
            chk("R6 irq one cycle", lock_irq, 0);
            chk("R4 single req", req_cnt - r0, 1);
            chk("R6 irq count", irq_cnt - i0, 1);
        end

        // R7 R8 all attempts fail
        r0 = req_cnt;
        i0 = irq_cnt;
        manual_start(6'h3F);
        chk("R5 fresh start clears lock", locked, 0);
        for (int k = 1; k <= N * MAX; k++) begin
            chk("R7 busy continuous", busy, 1);
            if (k < N * MAX) cyc(1);
        end
        cyc(1);
        chk("R8 busy after limit", busy, 0);
        chk("R8 error raised", cal_error, 1);
        chk("R5 unlocked code", locked, 0);
        chk("R5 result all ones", cal_result, 6'h3F);
        chk("R7 attempt count", req_cnt - r0, MAX);
        chk("R6 no irq on fail", irq_cnt - i0, 0);

        // R8 fresh start clears error
        manual_start(6'h2A);
        chk("R8 error cleared", cal_error, 0);
        cyc(N);
        chk("R8 locked after clear", locked, 1);
        chk("R8 result", cal_result, 6'h2A);

        // R7 retry then success
        r0 = req_cnt;
        i0 = irq_cnt;
        manual_start(6'h3F);
        cyc(N);
        trial_code = 6'h11;
        chk("R7 retry busy", busy, 1);
        chk("R7 retry req", cal_req, 1);
        cyc(N);
        chk("R7 done after two", busy, 0);
        chk("R7 result", cal_result, 6'h11);
        chk("R7 locked", locked, 1);
        chk("R7 no error", cal_error, 0);
        chk("R7 req count", req_cnt - r0, 2);
        chk("R7 irq count", irq_cnt - i0, 1);

        // R9 requests while busy ignored
        r0 = req_cnt;
        manual_start(6'h07);
        cal_strobe = 1'b1;
        auto_mode  = 2'd1;
        synth_on   = 1'b1;
        synth_off  = 1'b1;
        cyc(N);
        cal_strobe = 1'b0;
        synth_on   = 1'b0;
        synth_off  = 1'b0;
        auto_mode  = 2'd0;
        chk("R9 busy ends on time", busy, 0);
        chk("R9 result", cal_result, 6'h07);
        cyc(2);
        chk("R9 no extra req", req_cnt - r0, 1);
        chk("R9 still idle", busy, 0);

        // R10 sleep retention
        manual_start(6'h15);
        cyc(N);
        radio_state = 2'd1;
        trial_code  = 6'h3F;
        for (int k = 0; k < 8; k++) begin
            cal_strobe = k[0];
            synth_off  = k[1];
            cyc(1);
        end
        cal_strobe = 1'b0;
        synth_off  = 1'b0;
        chk("R10 result in sleep", cal_result, 6'h15);
        chk("R10 locked in sleep", locked, 1);
        radio_state = 2'd0;
        cyc(3);
        chk("R10 result after wake", cal_result, 6'h15);
        chk("R10 locked after wake", locked, 1);
        chk("R10 idle after wake", busy, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule